// File: doc/BRIEF.md
# Timer Input Capture Unit

This block pairs a free-running 16-bit counter with a capture register. When an event arrives, the counter value is copied into the capture register. The event is a chosen edge on either an external capture pin or an analog comparator result. Each capture sets a capture flag. An interrupt request is raised when that flag, its enable bit and the global interrupt enable are all set. The counter can also use the capture register as its wrap point. When it wraps, it sets an overflow flag.

A processor reaches the 16-bit values over an 8-bit bus. One staging byte holds the upper half and is shared by the counter and the capture register. Reading the lower half loads the staging byte with the upper half at the same moment, so the value the processor sees cannot be torn. Writing the upper half only fills the staging byte. The later lower-half write then commits both halves in one cycle.

Top module: `tmr_capture_unit`

## Requirements
- R1: When a capture event occurs, the capture register takes the counter value that was present in the cycle of the event, and the capture flag (flag register bit 5) is set. A capture event beats a processor write to the capture register in the same cycle, and setting the flag beats clearing it in the same cycle.
- R2: Control bit 0 picks the event source: 0 selects the capture pin and 1 selects the comparator input. Edges on the input that is not selected cause no capture.
- R3: Control bit 1 picks the edge: 1 means rising and 0 means falling. The input passes through two synchronizing flip-flops first, so the capture happens on the third rising clock edge after the input changes. The opposite edge causes no capture.
- R4: When control bit 2 is 1 and the counter equals the capture register, the counter goes to 0 on the next cycle. Otherwise it wraps from 0xFFFF to 0, and in all other cycles it adds 1.
- R5: Reading the lower byte returns that byte. In the same cycle, the upper byte of the same register is copied into the staging byte. Reading any upper-byte address returns the staging byte. Read data is registered and appears one cycle after the read strobe.
- R6: Writing an upper-byte address stores the byte in the staging byte only. Writing the lower-byte address loads the staging byte and the written byte into the 16-bit register at the same edge. A processor write to the counter takes priority over counting and wrapping.
- R7: Both interrupt outputs are registered. The capture request is the AND of the capture flag, mask bit 5 and the global enable, and the overflow request is the AND of the overflow flag, mask bit 2 and the global enable.
- R8: Writing a 1 to flag bit 5 clears the capture flag, and writing a 1 to flag bit 2 clears the overflow flag. Writing 0 to either bit leaves the flag unchanged.
- R9: An interrupt acknowledge pulse clears the capture flag.
- R10: The overflow flag (flag register bit 2) is set on every counter wrap, whether at the capture value or at 0xFFFF.
- R11: After reset, the counter, the capture register, the staging byte, control, mask, flags and both interrupt outputs are all 0.
- R12: The staging byte is shared. Reading an upper-byte address returns the upper half taken by the most recent lower-byte read or upper-byte write, whichever register that access was aimed at.

The bus addresses are: 0 = counter low, 1 = counter high, 2 = capture low, 3 = capture high, 4 = control, 5 = interrupt mask, 6 = flags. Address 7 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_pin | input | 1 | External capture input, asynchronous |
| acmp_out | input | 1 | Analog comparator result, asynchronous |
| gie | input | 1 | Global interrupt enable |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_ack | input | 1 | Capture interrupt acknowledge |
| cap_irq | output | 1 | Capture interrupt request |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
Captures are tried on both edges from both sources. Each edge is also applied with the wrong polarity and on the source that is not selected, which separates a missing source or edge selection from a correct one. Counter wrapping is driven in capture-as-wrap mode and at the full 16-bit limit, which shows whether the wrap comparison uses the right value. The 16-bit registers are accessed with a low read followed by a high read of the other register, which shows the staging byte is shared. A long randomized mix of reads, writes, flag clears, acknowledges and input toggles is then compared every clock against a behavioural model of the block.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CNT_L = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_H = 3'd1;
  localparam logic [ADDR_W-1:0] A_CAP_L = 3'd2;
  localparam logic [ADDR_W-1:0] A_CAP_H = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd4;
  localparam logic [ADDR_W-1:0] A_MASK  = 3'd5;
  localparam logic [ADDR_W-1:0] A_FLAG  = 3'd6;
  // bit positions shared by mask and flag registers
  localparam int CAP_BIT = 5;
  localparam int OVF_BIT = 2;
  // control bits
  localparam int SRC_BIT  = 0;
  localparam int EDGE_BIT = 1;
  localparam int TOP_BIT  = 2;
endpackage

// File: rtl/tcu_sync_edge.sv
module tcu_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic rise_sel,
  output logic evt
);
  logic [STAGES:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) sr_q <= '0;
    else     sr_q <= {sr_q[STAGES-1:0], din};
  end

  always_comb begin
    if (rise_sel) evt = sr_q[STAGES-1] & ~sr_q[STAGES];
    else          evt = ~sr_q[STAGES-1] & sr_q[STAGES];
  end
endmodule

// File: rtl/tcu_counter.sv
module tcu_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         top_en,
  input  logic [W-1:0] top_val,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  always_comb wrap = !ld && ((top_en && (cnt == top_val)) || (cnt == CNT_MAX));

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (ld)   cnt <= ld_val;
    else if (wrap) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tcu_bus_port.sv
module tcu_bus_port
  import tcu_pkg::*;
#(
  parameter int DW = 8,
  localparam int WW = 2 * DW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [DW-1:0]     wdata,
  input  logic [WW-1:0]     cnt_val,
  input  logic [WW-1:0]     cap_val,
  input  logic [DW-1:0]     ctrl_val,
  input  logic [DW-1:0]     mask_val,
  input  logic [DW-1:0]     flag_val,
  output logic [DW-1:0]     rdata,
  output logic [WW-1:0]     wide_val,
  output logic              cnt_ld,
  output logic              cap_ld
);
  logic [DW-1:0] tmp_q;
  logic [DW-1:0] rmux;

  always_comb begin
    wide_val = {tmp_q, wdata};
    cnt_ld   = wr && (addr == A_CNT_L);
    cap_ld   = wr && (addr == A_CAP_L);
  end

  always_comb begin
    case (addr)
      A_CNT_L: rmux = cnt_val[DW-1:0];
      A_CNT_H: rmux = tmp_q;
      A_CAP_L: rmux = cap_val[DW-1:0];
      A_CAP_H: rmux = tmp_q;
      A_CTRL:  rmux = ctrl_val;
      A_MASK:  rmux = mask_val;
      A_FLAG:  rmux = flag_val;
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmp_q <= '0;
      rdata <= '0;
    end else begin
      if (wr && ((addr == A_CNT_H) || (addr == A_CAP_H))) tmp_q <= wdata;
      else if (rd && (addr == A_CNT_L))                    tmp_q <= cnt_val[WW-1:DW];
      else if (rd && (addr == A_CAP_L))                    tmp_q <= cap_val[WW-1:DW];
      if (rd) rdata <= rmux;
    end
  end
endmodule

// File: rtl/tmr_capture_unit.sv
module tmr_capture_unit
  import tcu_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CW = 2 * DW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_pin,
  input  logic              acmp_out,
  input  logic              gie,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              irq_ack,
  output logic              cap_irq,
  output logic              ovf_irq
);
  logic [DW-1:0] ctrl_q, mask_q, flag_val;
  logic [CW-1:0] cnt_q, cap_q, wide_val;
  logic cap_flag, ovf_flag, cap_evt, wrap, cnt_ld, cap_ld, src_sel, top_en, flag_wr;

  always_comb begin
    src_sel  = ctrl_q[SRC_BIT] ? acmp_out : cap_pin;
    top_en   = ctrl_q[TOP_BIT];
    flag_wr  = bus_wr && (bus_addr == A_FLAG);
    flag_val = '0;
    flag_val[CAP_BIT] = cap_flag;
    flag_val[OVF_BIT] = ovf_flag;
  end

  tcu_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(src_sel), .rise_sel(ctrl_q[EDGE_BIT]), .evt(cap_evt)
  );

  tcu_counter #(.W(CW)) u_cnt (
    .clk(clk), .rst(rst), .ld(cnt_ld), .ld_val(wide_val), .top_en(top_en),
    .top_val(cap_q), .cnt(cnt_q), .wrap(wrap)
  );

  tcu_bus_port #(.DW(DW)) u_bus (
    .clk(clk), .rst(rst), .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .wdata(bus_wdata),
    .cnt_val(cnt_q), .cap_val(cap_q), .ctrl_val(ctrl_q), .mask_val(mask_q),
    .flag_val(flag_val), .rdata(bus_rdata), .wide_val(wide_val),
    .cnt_ld(cnt_ld), .cap_ld(cap_ld)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      mask_q   <= '0;
      cap_q    <= '0;
      cap_flag <= 1'b0;
      ovf_flag <= 1'b0;
      cap_irq  <= 1'b0;
      ovf_irq  <= 1'b0;
    end else begin
      if (bus_wr && (bus_addr == A_CTRL)) ctrl_q <= bus_wdata;
      if (bus_wr && (bus_addr == A_MASK)) mask_q <= bus_wdata;
      if (cap_evt)     cap_q <= cnt_q;
      else if (cap_ld) cap_q <= wide_val;
      cap_flag <= cap_evt | (cap_flag & ~(flag_wr & bus_wdata[CAP_BIT]) & ~irq_ack);
      ovf_flag <= wrap | (ovf_flag & ~(flag_wr & bus_wdata[OVF_BIT]));
      cap_irq  <= cap_flag & mask_q[CAP_BIT] & gie;
      ovf_irq  <= ovf_flag & mask_q[OVF_BIT] & gie;
    end
  end
endmodule

// File: rtl/tcu_checker.sv
module tcu_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          gie,
  input logic          irq_ack,
  input logic          cap_irq,
  input logic          ovf_irq,
  input logic          cap_evt,
  input logic          cap_flag,
  input logic          cnt_ld,
  input logic          top_en,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] cap_q
);
  assert_capture_value_R1: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> (cap_q == $past(cnt_q)));
  assert_capture_flag_R1: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> cap_flag);
  assert_top_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (top_en && (cnt_q == cap_q) && !cnt_ld) |=> (cnt_q == '0));
  assert_cap_irq_gate_R7: assert property (@(posedge clk) disable iff (rst)
    cap_irq |-> $past(gie));
  assert_ovf_irq_gate_R7: assert property (@(posedge clk) disable iff (rst)
    ovf_irq |-> $past(gie));
  assert_ack_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !cap_evt) |=> !cap_flag);
endmodule

bind tmr_capture_unit tcu_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .gie(gie), .irq_ack(irq_ack), .cap_irq(cap_irq),
  .ovf_irq(ovf_irq), .cap_evt(cap_evt), .cap_flag(cap_flag), .cnt_ld(cnt_ld),
  .top_en(top_en), .cnt_q(cnt_q), .cap_q(cap_q)
);

// File: tb/sim_tmr_capture_unit.sv
`timescale 1ns/1ps
module sim_tmr_capture_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cap_pin = 1'b0, acmp_out = 1'b0, gie = 1'b0, irq_ack = 1'b0;
  logic [2:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic cap_irq, ovf_irq;
  int n_tests = 0, n_fail = 0, cyc_n = 0;
  bit started = 0, done = 0;

  always #2.5 clk = ~clk;

  tmr_capture_unit u0 (
    .clk(clk), .rst(rst), .cap_pin(cap_pin), .acmp_out(acmp_out), .gie(gie),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_ack(irq_ack), .cap_irq(cap_irq), .ovf_irq(ovf_irq)
  );

  // behavioural reference model
  int m_cnt, m_cap, m_tmp, m_ctrl, m_mask, m_rdata;
  bit m_capf, m_ovff, m_cirq, m_oirq;
  bit m_sync[$];

  always @(posedge clk) begin
    started <= 1;
    if (rst) begin
      m_cnt = 0; m_cap = 0; m_tmp = 0; m_ctrl = 0; m_mask = 0; m_rdata = 0;
      m_capf = 0; m_ovff = 0; m_cirq = 0; m_oirq = 0;
      m_sync = '{0, 0, 0};
    end else begin
      bit src, evt, wrap, clr_c, clr_o;
      int n_cnt, n_cap, n_tmp;
      src = m_ctrl[0] ? acmp_out : cap_pin;
      evt = m_ctrl[1] ? (m_sync[1] && !m_sync[2]) : (!m_sync[1] && m_sync[2]);
      void'(m_sync.pop_back());
      m_sync.push_front(src);
      wrap = !(bus_wr && bus_addr == 0) &&
             ((m_ctrl[2] && m_cnt == m_cap) || m_cnt == 16'hFFFF);
      if (bus_wr && bus_addr == 0) n_cnt = m_tmp * 256 + bus_wdata;
      else if (wrap)               n_cnt = 0;
      else                         n_cnt = m_cnt + 1;
      if (evt)                           n_cap = m_cnt;
      else if (bus_wr && bus_addr == 2)  n_cap = m_tmp * 256 + bus_wdata;
      else                               n_cap = m_cap;
      n_tmp = m_tmp;
      if (bus_wr && (bus_addr == 1 || bus_addr == 3)) n_tmp = bus_wdata;
      else if (bus_rd && bus_addr == 0) n_tmp = m_cnt / 256;
      else if (bus_rd && bus_addr == 2) n_tmp = m_cap / 256;
      if (bus_rd) begin
        case (bus_addr)
          3'd0: m_rdata = m_cnt % 256;
          3'd1, 3'd3: m_rdata = m_tmp;
          3'd2: m_rdata = m_cap % 256;
          3'd4: m_rdata = m_ctrl;
          3'd5: m_rdata = m_mask;
          3'd6: m_rdata = (m_capf ? 32 : 0) + (m_ovff ? 4 : 0);
          default: m_rdata = 0;
        endcase
      end
      m_cirq = m_capf && m_mask[5] && gie;
      m_oirq = m_ovff && m_mask[2] && gie;
      clr_c = bus_wr && bus_addr == 6 && bus_wdata[5];
      clr_o = bus_wr && bus_addr == 6 && bus_wdata[2];
      m_capf = evt || (m_capf && !clr_c && !irq_ack);
      m_ovff = wrap || (m_ovff && !clr_o);
      if (bus_wr && bus_addr == 4) m_ctrl = bus_wdata;
      if (bus_wr && bus_addr == 5) m_mask = bus_wdata;
      m_cnt = n_cnt; m_cap = n_cap; m_tmp = n_tmp;
    end
  end

  task automatic chk(string req, int got, int exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !done) begin
      chk("R5 rdata vs model", int'(bus_rdata), m_rdata);
      chk("R7 cap_irq vs model", int'(cap_irq), int'(m_cirq));
      chk("R7 ovf_irq vs model", int'(ovf_irq), int'(m_oirq));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_n++;
    if (cyc_n > 100000 && !done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected < 100000", cyc_n);
      summary();
    end
  end

  initial begin
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    rd(3'd6, d); chk("R11 flags", d, 0);
    rd(3'd5, d); chk("R11 mask", d, 0);
    rd(3'd4, d); chk("R11 ctrl", d, 0);
    chk("R11 cap_irq", cap_irq, 0);
    // R6 / R5 atomic write then read of counter
    wr(3'd1, 8'h12); wr(3'd0, 8'h34);
    rd(3'd0, d); chk("R6 counter low", d, 8'h34);
    rd(3'd1, d); chk("R5 counter high via staging", d, 8'h12);
    // R12 shared staging byte
    wr(3'd3, 8'hAB); wr(3'd2, 8'hCD);
    rd(3'd2, d); chk("R12 capture low", d, 8'hCD);
    rd(3'd1, d); chk("R12 staging shared across addresses", d, 8'hAB);
    // R4 / R10 wrap at capture value
    wr(3'd3, 8'h00); wr(3'd2, 8'h08);
    wr(3'd4, 8'h04);
    wr(3'd1, 8'h00); wr(3'd0, 8'h00);
    idle(30);
    rd(3'd6, d); chk("R4 R10 overflow at capture value", d, 8'h04);
    wr(3'd4, 8'h00);
    wr(3'd1, 8'h01); wr(3'd0, 8'h00);
    // R8 write zero ignored, write one clears
    wr(3'd6, 8'h00);
    rd(3'd6, d); chk("R8 zero write ignored", d, 8'h04);
    wr(3'd6, 8'h04);
    rd(3'd6, d); chk("R8 one clears overflow", d, 8'h00);
    // R10 wrap at full range
    wr(3'd1, 8'hFF); wr(3'd0, 8'hFE);
    idle(4);
    rd(3'd6, d); chk("R10 overflow at 0xFFFF", d, 8'h04);
    wr(3'd6, 8'h04);
    // R1 / R3 rising edge on pin
    wr(3'd5, 8'h20); gie = 1'b1;
    wr(3'd4, 8'h02);
    cap_pin = 1'b1; idle(6);
    chk("R7 capture request raised", cap_irq, 1);
    rd(3'd6, d); chk("R1 capture flag set", d, 8'h20);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0; idle(2);
    chk("R9 ack clears request", cap_irq, 0);
    rd(3'd6, d); chk("R9 ack clears flag", d, 8'h00);
    cap_pin = 1'b0; idle(6);
    rd(3'd6, d); chk("R3 falling ignored in rising mode", d, 8'h00);
    // R3 falling edge
    wr(3'd4, 8'h00);
    cap_pin = 1'b1; idle(6);
    rd(3'd6, d); chk("R3 rising ignored in falling mode", d, 8'h00);
    cap_pin = 1'b0; idle(6);
    rd(3'd6, d); chk("R3 falling captured", d, 8'h20);
    wr(3'd6, 8'h20);
    // R2 comparator source
    wr(3'd4, 8'h01);
    cap_pin = 1'b1; idle(5); cap_pin = 1'b0; idle(6);
    rd(3'd6, d); chk("R2 pin ignored when comparator selected", d, 8'h00);
    acmp_out = 1'b1; idle(5); acmp_out = 1'b0; idle(6);
    rd(3'd6, d); chk("R2 comparator captured", d, 8'h20);
    // R7 global gate
    gie = 1'b0; idle(3);
    chk("R7 request blocked by global enable", cap_irq, 0);
    gie = 1'b1; idle(2);
    chk("R7 request with global enable", cap_irq, 1);
    wr(3'd6, 8'h24);
    // randomized phase against the model
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = $urandom_range(0, 9);
      irq_ack = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 31) == 0) gie = ~gie;
      if ($urandom_range(0, 7) == 0) cap_pin = ~cap_pin;
      if ($urandom_range(0, 7) == 0) acmp_out = ~acmp_out;
      bus_addr = 3'($urandom_range(0, 7));
      bus_wdata = 8'($urandom);
      bus_rd = (op < 4);
      bus_wr = (op == 4 || op == 5);
      @(negedge clk);
      bus_rd = 1'b0; bus_wr = 1'b0; irq_ack = 1'b0;
    end
    idle(2);
    summary();
  end
endmodule